// File: doc/BRIEF.md
# Dual DAC Serial Register Interface

This block is the digital side of a two-channel, 10-bit voltage DAC that is programmed through a three-wire serial port (serial clock, serial data, active-low select). The serial pins are resynchronised into a system clock domain. A 16-bit word is collected MSB first and decoded into commands. The commands fill per-channel staging registers, move staged codes into the output registers, make a channel write straight through, and put channels to sleep or wake them.

Each channel holds a staging register and an output register. The output register code is what the analog string converts. The channels can be staged one at a time and then committed together. While a channel sleeps, its output pin is steered to one of three termination states and its register contents are left untouched. After a wake-up, a recovery window is timed on the system clock, and output-register writes are refused until that window has closed.

Top module: `dualdac_serial_core`

## Requirements
- R1: After reset both channels are asleep with termination code 2 (100 kΩ), all staging and output registers are 0, both channels are non-transparent and `wake_busy` is low.
- R2: While `cs_n` is low, a word is built MSB first from `din` sampled at each falling `sclk` edge. Bits [15:12] are the command, bits [11:2] are the data, and bits [1:0] are ignored. The word acts on the 16th falling edge without waiting for `cs_n` to rise, and its result is visible 3 `clk` rising edges after that `sclk` edge.
- R3: If `cs_n` goes high before the 16th falling `sclk` edge of a frame, the partial word is dropped and no register changes.
- R4: After the 16th bit, further `sclk` edges are ignored until `cs_n` falls again.
- R5: Command 0x1 writes the data into staging register A, and command 0x2 writes it into staging register B. The output codes do not change unless that channel is transparent.
- R6: Command 0x3 copies both staging registers into the output registers. Command 0x4 stages A and then commits both, and command 0x5 stages B and then commits both, so the committed value of the staged channel is the new data.
- R7: Command 0x8 sets channel A transparent from data bit 9 and channel B from data bit 8. A staging write to a transparent channel also writes its output register.
- R8: Command 0xC acts on channel A when data bit 9 is 1 and on channel B when data bit 8 is 1. Data bit 2 set to 1 puts the selected channels to sleep at once and loads their termination from data bits 1:0 (0 floating, 1 1 kΩ, 2 100 kΩ, 3 stored as 2). Data bit 2 set to 0 wakes them. Output codes are kept across sleep and wake.
- R9: A wake command that selects at least one channel raises `wake_busy` for exactly WAKE_CYC = CLK_HZ·8 µs clock cycles (800 at 100 MHz). During that window, output-register writes (commit or transparent) are ignored, while staging writes, transparency and sleep commands still act.
- R10: Command codes other than 0x1–0x5, 0x8 and 0xC change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial data, asynchronous |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| code_a | output | 10 | Output register code, channel A |
| code_b | output | 10 | Output register code, channel B |
| pwrdn_a | output | 1 | Channel A asleep |
| pwrdn_b | output | 1 | Channel B asleep |
| term_a | output | 2 | Channel A sleep termination select |
| term_b | output | 2 | Channel B sleep termination select |
| wake_busy | output | 1 | Recovery window running |

## Verification
A register effect is due on the third `clk` rising edge after the 16th falling `sclk` edge. The bench therefore drives serial pins just after a rising edge, waits three edges after the final fall, and updates its behavioural model at that moment. The model and the ports are compared on every falling `clk` edge. The recovery counter in the model starts at WAKE_CYC on the command edge and counts down once per compare, so `wake_busy` is checked in its first and last cycle, and the commands sent inside the window are judged against the exact busy state.

// File: rtl/dualdac_serial_core.sv
module dualdac_serial_core #(
  parameter int CLK_HZ     = 100_000_000,
  parameter int DW         = 10,
  parameter int RECOVER_NS = 8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          din,
  input  logic          cs_n,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b,
  output logic          pwrdn_a,
  output logic          pwrdn_b,
  output logic [1:0]    term_a,
  output logic [1:0]    term_b,
  output logic          wake_busy
);
  localparam int FW       = DW + 6;
  localparam int BW       = $clog2(FW);
  localparam int WAKE_CYC = ((CLK_HZ / 1000) * RECOVER_NS) / 1_000_000;
  localparam int CW       = $clog2(WAKE_CYC + 1);

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    din_q;
  logic [FW-2:0] sh;
  logic [BW-1:0] nbit;
  logic          armed;
  logic [CW-1:0] wcnt;
  logic [DW-1:0] in_a, in_b;
  logic          tr_a, tr_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      din_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      cs_q  <= {cs_q[1:0], cs_n};
      din_q <= {din_q[0], din};
    end

  wire sck_fall = sck_q[2] & ~sck_q[1];
  wire cs_fall  = cs_q[2] & ~cs_q[1];
  wire cs_hi    = cs_q[1];
  wire fire     = armed & ~cs_hi & sck_fall & (nbit == BW'(FW - 1));

  wire [FW-1:0] word = {sh, din_q[1]};
  wire [3:0]    cmd  = word[FW-1 -: 4];
  wire [DW-1:0] dat  = word[FW-5 -: DW];
  wire          sel_a = dat[DW-1];
  wire          sel_b = dat[DW-2];
  wire          sleep = dat[2];
  wire [1:0]    tsel  = (dat[1:0] == 2'b11) ? 2'b10 : dat[1:0];

  assign wake_busy = (wcnt != '0);

  wire ld_a  = fire & ((cmd == 4'h1) | (cmd == 4'h4));
  wire ld_b  = fire & ((cmd == 4'h2) | (cmd == 4'h5));
  wire upd   = fire & ((cmd == 4'h3) | (cmd == 4'h4) | (cmd == 4'h5)) & ~wake_busy;
  wire trcmd = fire & (cmd == 4'h8);
  wire pwcmd = fire & (cmd == 4'hC);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      nbit  <= '0;
      sh    <= '0;
    end else if (cs_hi) begin
      armed <= 1'b0;
      nbit  <= '0;
    end else if (cs_fall) begin
      armed <= 1'b1;
      nbit  <= '0;
    end else if (armed && sck_fall) begin
      sh   <= {sh[FW-3:0], din_q[1]};
      nbit <= nbit + 1'b1;
      if (nbit == BW'(FW - 1)) armed <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_a   <= '0;
      in_b   <= '0;
      code_a <= '0;
      code_b <= '0;
      tr_a   <= 1'b0;
      tr_b   <= 1'b0;
    end else begin
      if (ld_a) in_a <= dat;
      if (ld_b) in_b <= dat;
      if (upd) begin
        code_a <= ld_a ? dat : in_a;
        code_b <= ld_b ? dat : in_b;
      end else begin
        if (ld_a && tr_a && !wake_busy) code_a <= dat;
        if (ld_b && tr_b && !wake_busy) code_b <= dat;
      end
      if (trcmd) begin
        tr_a <= sel_a;
        tr_b <= sel_b;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pwrdn_a <= 1'b1;
      pwrdn_b <= 1'b1;
      term_a  <= 2'b10;
      term_b  <= 2'b10;
      wcnt    <= '0;
    end else begin
      if (pwcmd && sel_a) begin
        pwrdn_a <= sleep;
        if (sleep) term_a <= tsel;
      end
      if (pwcmd && sel_b) begin
        pwrdn_b <= sleep;
        if (sleep) term_b <= tsel;
      end
      if (pwcmd && !sleep && (sel_a || sel_b)) wcnt <= CW'(WAKE_CYC);
      else if (wcnt != '0)                     wcnt <= wcnt - 1'b1;
    end
endmodule

module dualdac_serial_chk #(parameter int DW = 10) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] code_a,
  input logic [DW-1:0] code_b,
  input logic          pwrdn_a,
  input logic          pwrdn_b,
  input logic [1:0]    term_a,
  input logic [1:0]    term_b,
  input logic          wake_busy
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwrdn_a && pwrdn_b && term_a == 2'b10 && term_b == 2'b10
                      && code_a == '0 && code_b == '0 && !wake_busy));
  // R9
  busy_blocks_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_busy |=> ($stable(code_a) && $stable(code_b)));
  // R9
  wake_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwrdn_a) || $fell(pwrdn_b)) |-> wake_busy);
  // R8
  term_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_a != 2'b11) && (term_b != 2'b11));
  // R8
  sleep_keeps_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwrdn_a) || $rose(pwrdn_b)) |-> ($stable(code_a) && $stable(code_b)));
endmodule

bind dualdac_serial_core dualdac_serial_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_a(code_a), .code_b(code_b),
  .pwrdn_a(pwrdn_a), .pwrdn_b(pwrdn_b), .term_a(term_a), .term_b(term_b),
  .wake_busy(wake_busy));

// File: tb/sim_dualdac_serial_core.sv
`timescale 1ns/1ps
module sim_dualdac_serial_core;
  localparam int WAKE = 800;

  logic clk = 0, rst_n = 0, sclk = 0, din = 0, cs_n = 1;
  logic [9:0] code_a, code_b;
  logic pwrdn_a, pwrdn_b, wake_busy;
  logic [1:0] term_a, term_b;

  dualdac_serial_core u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [9:0] m_in_a, m_in_b, m_dac_a, m_dac_b;
  logic m_tr_a, m_tr_b, m_pd_a, m_pd_b;
  logic [1:0] m_t_a, m_t_b;
  int m_busy;

  task automatic model_reset();
    m_in_a = 0; m_in_b = 0; m_dac_a = 0; m_dac_b = 0;
    m_tr_a = 0; m_tr_b = 0; m_pd_a = 1; m_pd_b = 1;
    m_t_a = 2; m_t_b = 2; m_busy = 0;
  endtask

  task automatic model_exec(input logic [15:0] w);
    logic [3:0] c; logic [9:0] d; bit busy;
    c = w[15:12]; d = w[11:2]; busy = (m_busy > 0);
    case (c)
      4'h1: begin m_in_a = d; if (m_tr_a && !busy) m_dac_a = d; end
      4'h2: begin m_in_b = d; if (m_tr_b && !busy) m_dac_b = d; end
      4'h3: if (!busy) begin m_dac_a = m_in_a; m_dac_b = m_in_b; end
      4'h4: begin m_in_a = d; if (!busy) begin m_dac_a = m_in_a; m_dac_b = m_in_b; end end
      4'h5: begin m_in_b = d; if (!busy) begin m_dac_a = m_in_a; m_dac_b = m_in_b; end end
      4'h8: begin m_tr_a = d[9]; m_tr_b = d[8]; end
      4'hC: begin
        if (d[9]) begin m_pd_a = d[2]; if (d[2]) m_t_a = (d[1:0] == 3) ? 2'd2 : d[1:0]; end
        if (d[8]) begin m_pd_b = d[2]; if (d[2]) m_t_b = (d[1:0] == 3) ? 2'd2 : d[1:0]; end
        if (!d[2] && (d[9] || d[8])) m_busy = WAKE;
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 cycle-by-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 model", {5'b0, code_a, code_b, pwrdn_a, pwrdn_b, term_a, term_b, wake_busy},
        {5'b0, m_dac_a, m_dac_b, m_pd_a, m_pd_b, m_t_a, m_t_b, (m_busy > 0)});
    if (m_busy > 0) m_busy--;
  end

  task automatic frame(input logic [31:0] w, input int n);
    @(posedge clk); #1 cs_n = 0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < n; i++) begin
      #1 sclk = 1; din = w[31-i];
      repeat (4) @(posedge clk);
      #1 sclk = 0;
      if (i == 15) begin
        repeat (3) @(posedge clk);
        model_exec(w[31:16]);
      end else repeat (4) @(posedge clk);
    end
    repeat (3) @(posedge clk);
    #1 cs_n = 1;
    repeat (6) @(posedge clk);
  endtask

  task automatic send(input logic [3:0] c, input logic [9:0] d, input logic [1:0] s = 2'b00);
    frame({c, d, s, 16'h0}, 16);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    idle(2);
    // R1 reset state
    chk("R1 codes", {code_a, code_b}, 20'h0);
    chk("R1 sleep/term", {pwrdn_a, pwrdn_b, term_a, term_b, wake_busy}, {1'b1, 1'b1, 2'd2, 2'd2, 1'b0});

    // R8 wake both, R9 busy window
    send(4'hC, 10'h300);
    idle(1);
    chk("R9 busy after wake", wake_busy, 1);
    chk("R8 awake", {pwrdn_a, pwrdn_b}, 2'b00);
    send(4'h4, 10'h1A5);
    idle(1);
    chk("R9 commit blocked", code_a, 0);
    wait (!wake_busy);
    idle(2);
    send(4'h3, 10'h000);
    idle(1);
    chk("R9 staging kept", code_a, 10'h1A5);

    // R5 staging only
    send(4'h1, 10'h155);
    send(4'h2, 10'h2AA);
    idle(1);
    chk("R5 no output change", {code_a, code_b}, {10'h1A5, 10'h000});
    // R6 commit both
    send(4'h3, 10'h000);
    idle(1);
    chk("R6 commit", {code_a, code_b}, {10'h155, 10'h2AA});
    send(4'h5, 10'h3FF);
    idle(1);
    chk("R6 stage B and commit", {code_a, code_b}, {10'h155, 10'h3FF});
    send(4'h4, 10'h001);
    idle(1);
    chk("R6 stage A and commit", code_a, 10'h001);

    // R7 transparency on A only
    send(4'h8, 10'h200);
    send(4'h1, 10'h0AB);
    send(4'h2, 10'h011);
    idle(1);
    chk("R7 transparent A, latched B", {code_a, code_b}, {10'h0AB, 10'h3FF});

    // R3 short frames dropped
    frame({4'h1, 10'h3FF, 2'b00, 16'h0}, 10);
    frame({4'h1, 10'h3FF, 2'b00, 16'h0}, 15);
    idle(1);
    chk("R3 aborted frames", code_a, 10'h0AB);

    // R4 extra bits after 16th ignored
    frame({4'h1, 10'h123, 2'b00, 4'h1, 10'h3FF, 2'b00}, 32);
    idle(1);
    chk("R4 extra edges ignored", code_a, 10'h123);

    // R2 trailing bits ignored
    send(4'h1, 10'h0F0, 2'b11);
    idle(1);
    chk("R2 trailing bits", code_a, 10'h0F0);

    // R10 undefined commands
    send(4'h7, 10'h3FF);
    send(4'h0, 10'h3FF);
    send(4'hE, 10'h3FF);
    idle(1);
    chk("R10 no effect", {code_a, code_b, pwrdn_a, pwrdn_b}, {10'h0F0, 10'h3FF, 2'b00});

    // R8 sleep with terminations, codes kept
    send(4'hC, 10'h205);
    idle(1);
    chk("R8 A 1k", {pwrdn_a, term_a, code_a}, {1'b1, 2'd1, 10'h0F0});
    send(4'hC, 10'h107);
    idle(1);
    chk("R8 B code3 as 100k", {pwrdn_b, term_b, code_b}, {1'b1, 2'd2, 10'h3FF});
    send(4'hC, 10'h204);
    idle(1);
    chk("R8 A floating", term_a, 2'd0);
    send(4'hC, 10'h200);
    idle(1);
    chk("R8 A wake keeps code", {pwrdn_a, code_a, wake_busy}, {1'b0, 10'h0F0, 1'b1});
    // R9 sleep acts during busy, transparent write refused
    send(4'hC, 10'h104);
    send(4'h1, 10'h055);
    idle(1);
    chk("R9 sleep during busy", pwrdn_b, 1);
    chk("R9 transparent write refused", code_a, 10'h0F0);
    wait (!wake_busy);
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule